// File: doc/BRIEF.md
# Configuration Readback Command Sequencer

This block drives the 32-bit internal configuration port of a programmable device through a fixed script that reads configuration frames back out of the fabric. A single start pulse, together with a starting frame address and a frame count, launches the script. The block writes a short header of command words on the write strobe. It turns the port around to the read direction and pulls the readback burst on the read strobe. It then turns the port back, writes a short closing script, and signals completion.

The readback words appear on a simple valid/data stream one cycle after the port delivers them. The burst length is derived from the frame count. Each frame holds 41 words, one extra frame is read to drain the frame buffer, and one extra word is read after that. The same length is written into the count field of the read-packet header. Every command encoding is a parameter, so the block is not tied to one bit layout.

The port may assert a busy signal at any time. While it is high, the sequencer holds its current word and strobe and does not advance.

Top module: `rdbk_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `port_wr`, `port_rd`, `port_read_mode`, `rb_valid`, `done` and `seq_busy` are all 0.
- R2: After a start, the first eight accepted write words are, in order: sync word, NOP, command-register header, read-configuration code, NOP, frame-address-register header, the starting frame address, read-packet header.
- R3: The read-packet header equals the header base with the burst length L = 41 × (frame_count + 1) + 1 placed in its count field at bit CNT_LSB, CNT_W bits wide (bits [10:0] by default).
- R4: Exactly L read strobes are accepted. The readback word accepted on the k-th accepted read appears as the k-th `rb_valid` beat, in the cycle after it was accepted.
- R5: After the burst, exactly three more words are accepted, in order: NOP, command-register header, desynchronise code. The read strobe is not used before all eight header words are accepted.
- R6: `port_wr` and `port_rd` are never high together. `port_read_mode` (1 = read direction) changes only in a cycle where both strobes are low.
- R7: A word or read counts only in a cycle with `port_busy` low. While `port_busy` is high, the strobe and write word are held, so no word is skipped or repeated.
- R8: `done` is high for exactly one cycle, in the cycle after the desynchronise word is accepted. `seq_busy` is high from the cycle after start until `done` has been given.
- R9: A start pulse while `seq_busy` is high is ignored. The running script keeps its original length, and no second script follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| start_frame | input | 32 | First frame address to read |
| frame_count | input | FCW | Number of frames requested |
| port_busy | input | 1 | Port stall: hold current step |
| port_rdata | input | 32 | Readback word from the port |
| port_wr | output | 1 | Write strobe |
| port_rd | output | 1 | Read strobe |
| port_read_mode | output | 1 | Port direction, 1 = read |
| port_wdata | output | 32 | Command word to the port |
| rb_valid | output | 1 | Readback stream valid |
| rb_data | output | 32 | Readback stream word |
| seq_busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The script is run for every frame count from zero to three and for the largest count, with the port either always ready or stalling every third cycle. This separates errors in the length arithmetic from errors in stall handling. Readback data is a numbered pattern, so a dropped, duplicated or reordered beat shows up directly. A mid-burst start carrying a different frame count checks that a running script cannot be restarted or resized. Varied frame addresses confirm that the address word passes through unchanged.

// File: rtl/rdbk_pkg.sv
package rdbk_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_HEAD   = 3'd1,
        S_TURN_R = 3'd2,
        S_READ   = 3'd3,
        S_TURN_W = 3'd4,
        S_TAIL   = 3'd5,
        S_FIN    = 3'd6
    } seq_state_e;

    localparam int          HEAD_WORDS = 8;
    localparam int          TAIL_WORDS = 3;
    localparam logic [2:0]  HEAD_LAST  = 3'(HEAD_WORDS - 1);
    localparam logic [2:0]  TAIL_LAST  = 3'(TAIL_WORDS - 1);

endpackage

// File: rtl/rdbk_len.sv
module rdbk_len #(
    parameter int FCW = 4,
    parameter int WPF = 41,
    parameter int LW  = 11
) (
    input  logic [FCW-1:0] frames,
    output logic [LW-1:0]  len
);
    localparam int          NB    = 8;
    localparam logic [NB-1:0] WPF_V = NB'(WPF);

    logic [LW-1:0] f1;
    logic [LW-1:0] term [NB];
    logic [LW-1:0] acc;

    assign f1 = LW'(frames) + LW'(1);

    // shift-and-add: one partial term per set bit of the words-per-frame constant
    for (genvar g = 0; g < NB; g++) begin : g_term
        if (WPF_V[g]) begin : g_on
            assign term[g] = f1 << g;
        end else begin : g_off
            assign term[g] = '0;
        end
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NB; i++) acc = acc + term[i];
        len = acc + LW'(1);
    end
endmodule

// File: rtl/rdbk_words.sv
module rdbk_words
    import rdbk_pkg::*;
#(
    parameter int    LW          = 11,
    parameter int    CNT_LSB     = 0,
    parameter word_t SYNC_WORD   = 32'hAA995566,
    parameter word_t NOP_WORD    = 32'h20000000,
    parameter word_t CMD_HDR     = 32'h30008001,
    parameter word_t RCFG_CODE   = 32'h00000004,
    parameter word_t FAR_HDR     = 32'h30002001,
    parameter word_t RD_HDR      = 32'h28006000,
    parameter word_t DESYNC_CODE = 32'h0000000D
) (
    input  seq_state_e    st,
    input  logic [2:0]    idx,
    input  word_t         far,
    input  logic [LW-1:0] len,
    output word_t         word
);
    word_t rd_hdr_full;
    assign rd_hdr_full = RD_HDR | (32'(len) << CNT_LSB);

    always_comb begin
        word = '0;
        if (st == S_HEAD) begin
            case (idx)
                3'd0:    word = SYNC_WORD;
                3'd1:    word = NOP_WORD;
                3'd2:    word = CMD_HDR;
                3'd3:    word = RCFG_CODE;
                3'd4:    word = NOP_WORD;
                3'd5:    word = FAR_HDR;
                3'd6:    word = far;
                default: word = rd_hdr_full;
            endcase
        end else if (st == S_TAIL) begin
            case (idx)
                3'd0:    word = NOP_WORD;
                3'd1:    word = CMD_HDR;
                default: word = DESYNC_CODE;
            endcase
        end
    end
endmodule

// File: rtl/rdbk_capture.sv
module rdbk_capture
    import rdbk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  word_t din,
    output logic  valid,
    output word_t data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= take;
            if (take) data <= din;
        end
    end
endmodule

// File: rtl/rdbk_seq.sv
module rdbk_seq
    import rdbk_pkg::*;
#(
    parameter int    FCW         = 4,
    parameter int    WPF         = 41,
    parameter int    CNT_W       = 11,
    parameter int    CNT_LSB     = 0,
    parameter word_t SYNC_WORD   = 32'hAA995566,
    parameter word_t NOP_WORD    = 32'h20000000,
    parameter word_t CMD_HDR     = 32'h30008001,
    parameter word_t RCFG_CODE   = 32'h00000004,
    parameter word_t FAR_HDR     = 32'h30002001,
    parameter word_t RD_HDR      = 32'h28006000,
    parameter word_t DESYNC_CODE = 32'h0000000D
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [31:0]    start_frame,
    input  logic [FCW-1:0] frame_count,
    input  logic           port_busy,
    input  logic [31:0]    port_rdata,
    output logic           port_wr,
    output logic           port_rd,
    output logic           port_read_mode,
    output logic [31:0]    port_wdata,
    output logic           rb_valid,
    output logic [31:0]    rb_data,
    output logic           seq_busy,
    output logic           done
);
    localparam int LW = CNT_W;

    seq_state_e    state;
    logic [2:0]    idx;
    logic [LW-1:0] rcnt;
    logic [LW-1:0] len_q;
    logic [LW-1:0] len_calc;
    word_t         far_q;
    word_t         word;
    logic          adv;

    assign adv = !port_busy;

    rdbk_len #(.FCW(FCW), .WPF(WPF), .LW(LW)) u_len (
        .frames (frame_count),
        .len    (len_calc)
    );

    rdbk_words #(
        .LW(LW), .CNT_LSB(CNT_LSB), .SYNC_WORD(SYNC_WORD), .NOP_WORD(NOP_WORD),
        .CMD_HDR(CMD_HDR), .RCFG_CODE(RCFG_CODE), .FAR_HDR(FAR_HDR),
        .RD_HDR(RD_HDR), .DESYNC_CODE(DESYNC_CODE)
    ) u_words (
        .st   (state),
        .idx  (idx),
        .far  (far_q),
        .len  (len_q),
        .word (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            idx   <= '0;
            rcnt  <= '0;
            len_q <= '0;
            far_q <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        far_q <= start_frame;
                        len_q <= len_calc;
                        idx   <= '0;
                        state <= S_HEAD;
                    end
                end
                S_HEAD: begin
                    if (adv) begin
                        if (idx == HEAD_LAST) begin
                            idx   <= '0;
                            state <= S_TURN_R;
                        end else begin
                            idx <= idx + 3'd1;
                        end
                    end
                end
                S_TURN_R: begin
                    rcnt  <= '0;
                    state <= S_READ;
                end
                S_READ: begin
                    if (adv) begin
                        if (rcnt == len_q - LW'(1)) state <= S_TURN_W;
                        else                        rcnt  <= rcnt + LW'(1);
                    end
                end
                S_TURN_W: begin
                    idx   <= '0;
                    state <= S_TAIL;
                end
                S_TAIL: begin
                    if (adv) begin
                        if (idx == TAIL_LAST) state <= S_FIN;
                        else                  idx   <= idx + 3'd1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign port_wr        = (state == S_HEAD) || (state == S_TAIL);
    assign port_rd        = (state == S_READ);
    assign port_read_mode = (state == S_TURN_R) || (state == S_READ);
    assign port_wdata     = port_wr ? word : '0;
    assign seq_busy       = (state != S_IDLE);
    assign done           = (state == S_FIN);

    rdbk_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .take  (port_rd && !port_busy),
        .din   (port_rdata),
        .valid (rb_valid),
        .data  (rb_data)
    );

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(port_wr && port_rd));

    // R6
    turn_dead_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(port_read_mode) |-> (!port_wr && !port_rd));

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (port_wr && port_busy) |=> (port_wr && $stable(port_wdata)));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (port_rd && port_busy) |=> port_rd);

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (port_rd && !port_busy) |=> (rb_valid && rb_data == $past(port_rdata)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && start) |=> $stable(len_q));
endmodule

// File: tb/rdbk_seq_test.sv
module rdbk_seq_test;
    localparam logic [31:0] SYNC   = 32'hAA995566;
    localparam logic [31:0] NOP    = 32'h20000000;
    localparam logic [31:0] CMDH   = 32'h30008001;
    localparam logic [31:0] RCFG   = 32'h00000004;
    localparam logic [31:0] FARH   = 32'h30002001;
    localparam logic [31:0] RDH    = 32'h28006000;
    localparam logic [31:0] DESYNC = 32'h0000000D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_frame = '0;
    logic [3:0]  frame_count = '0;
    logic        port_busy = 1'b0;
    logic [31:0] port_rdata = '0;
    logic        port_wr, port_rd, port_read_mode, rb_valid, seq_busy, done;
    logic [31:0] port_wdata, rb_data;

    rdbk_seq uut (
        .clk(clk), .rst(rst), .start(start), .start_frame(start_frame),
        .frame_count(frame_count), .port_busy(port_busy), .port_rdata(port_rdata),
        .port_wr(port_wr), .port_rd(port_rd), .port_read_mode(port_read_mode),
        .port_wdata(port_wdata), .rb_valid(rb_valid), .rb_data(rb_data),
        .seq_busy(seq_busy), .done(done)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [31:0] wlog [16];
    int wn, acc, got, mism, first_rd_wn, both_err, dead_err, done_cnt, done_long, cyc;
    bit busy_mode, prev_mode, prev_done, active;

    function automatic logic [31:0] rb_pat(int k);
        return 32'h5A000000 + 32'(k) * 32'd3;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (active) begin
            if (rb_valid) begin
                if (rb_data != rb_pat(got)) mism++;
                got++;
            end
            if (port_wr && port_rd) both_err++;
            if ((port_read_mode != prev_mode) && (port_wr || port_rd)) dead_err++;
            prev_mode = port_read_mode;
            if (done) begin
                done_cnt++;
                if (prev_done) done_long++;
            end
            prev_done = done;
            port_busy = busy_mode && (cyc % 3 == 1);
            cyc++;
            port_rdata = rb_pat(acc);
            if (port_wr && !port_busy) begin
                if (wn < 16) wlog[wn] = port_wdata;
                wn++;
            end
            if (port_rd && !port_busy) begin
                if (acc == 0) first_rd_wn = wn;
                acc++;
            end
        end
    end

    task automatic run(int frames, logic [31:0] far, bit bmode, bit glitch);
        int len, t;
        logic [31:0] exp_w [11];
        len = 41 * (frames + 1) + 1;
        exp_w = '{SYNC, NOP, CMDH, RCFG, NOP, FARH, far, RDH | 32'(len), NOP, CMDH, DESYNC};
        @(posedge clk); #1;
        wn = 0; acc = 0; got = 0; mism = 0; first_rd_wn = -1; both_err = 0;
        dead_err = 0; done_cnt = 0; done_long = 0;
        busy_mode = bmode;
        start = 1'b1; frame_count = 4'(frames); start_frame = far;
        @(posedge clk); #1;
        start = 1'b0;
        chk(seq_busy == 1'b1, "R8", "busy after start", 32'(seq_busy), 32'd1);
        if (glitch) begin
            repeat (60) @(posedge clk);
            #1; start = 1'b1; frame_count = 4'(frames + 2); start_frame = ~far;
            @(posedge clk); #1; start = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 5000) begin
            @(posedge clk); #1; t++;
        end
        chk(t < 5000, "R8", "done seen", 32'(t), 32'd0);
        repeat (20) @(posedge clk);
        #1;
        chk(wn == 11, "R7", "accepted write count", 32'(wn), 32'd11);
        for (int i = 0; i < 8; i++)
            chk(wlog[i] == exp_w[i], (i == 7) ? "R3" : "R2", "head word", wlog[i], exp_w[i]);
        for (int i = 8; i < 11; i++)
            chk(wlog[i] == exp_w[i], "R5", "tail word", wlog[i], exp_w[i]);
        chk(first_rd_wn == 8, "R5", "reads start after header", 32'(first_rd_wn), 32'd8);
        chk(acc == len, glitch ? "R9" : "R4", "accepted reads", 32'(acc), 32'(len));
        chk(got == len, "R4", "stream beats", 32'(got), 32'(len));
        chk(mism == 0, "R4", "stream data order", 32'(mism), 32'd0);
        chk(both_err == 0 && dead_err == 0, "R6", "turnaround", 32'(both_err + dead_err), 32'd0);
        chk(done_cnt == 1 && done_long == 0, "R8", "done pulse", 32'(done_cnt), 32'd1);
        chk(seq_busy == 1'b0, "R9", "idle after script", 32'(seq_busy), 32'd0);
        busy_mode = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk({port_wr, port_rd, port_read_mode, rb_valid, done, seq_busy} == 6'b0,
            "R1", "outputs in reset", 32'({port_wr, port_rd, port_read_mode, rb_valid, done, seq_busy}), 32'd0);
        rst = 1'b0;
        active = 1'b1;
        @(negedge clk);
        chk({port_wr, port_rd, port_read_mode, rb_valid, done, seq_busy} == 6'b0,
            "R1", "outputs after reset", 32'({port_wr, port_rd, port_read_mode, rb_valid, done, seq_busy}), 32'd0);
        for (int b = 0; b < 2; b++)
            for (int f = 0; f < 4; f++)
                run(f, 32'h00400000 + 32'(f * 32'h1100) + 32'(b * 32'h80000000), b[0], 1'b0);
        run(15, 32'hFFFFFFFF, 1'b1, 1'b0);
        run(1, 32'h00123456, 1'b0, 1'b1);
        run(2, 32'h00ABCDEF, 1'b1, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule